// File: doc/BRIEF.md
# Ten-Input Tick Selector with Fractional Divider

This block is the last stage of a peripheral clock generator. It picks one of ten tick sources with a select field, then divides the picked tick stream by a ratio made of an integer part and a fraction. The result is a single-cycle enable pulse on `out_tick`. All sources are single-cycle enables in the block's own clock domain. Their rate comes from upstream stages that are not part of this block.

Input 0 is tied to ground. Input 1 carries the main oscillator tick, and inputs 2 and 3 carry two debug ticks taken from other selectors. Inputs 4 to 9 depend on the instance. A build-time mask marks which of them are wired, and a masked input acts as ground. In instances built with the dual-channel option, input 4 is itself a two-way choice between `src_tick[4]` and `alt_tick`, steered by `alt_sel`.

The fraction is applied with an accumulator. When a period ends, the fractional value is added to the accumulator. An overflow lengthens the next period by one tick, so the long-run ratio is `cfg_int + cfg_frac / 2^FRAC_W`. A new setting is held in a shadow until the period in progress completes.

Top module: `tick_mux_fdiv`

## Requirements
- R1: While `rst_n` is low and after reset is released, `out_tick` is 0 until a live setting has been loaded and has counted a full period.
- R2: `cfg_src` values 1 to 8 select `src_tick[cfg_src]`. The ticks on unselected inputs have no effect on the output.
- R3: `cfg_src` = 0, `cfg_src` from 10 to 15, and an input cleared in `POP_MASK` (input 9 by default) all produce no pulse on `out_tick`.
- R4: With `HAS_ALT4`=1 and `cfg_src`=4, the block counts `src_tick[4]` when `alt_sel`=0 and `alt_tick` when `alt_sel`=1.
- R5: Number the periods of a setting k = 0, 1, 2, and so on. Period 0 lasts exactly `cfg_int` selected ticks. Period k≥1 lasts `cfg_int + floor(k*F/2^FRAC_W) - floor((k-1)*F/2^FRAC_W)` ticks, where F is `cfg_frac`.
- R6: Over N periods, the total count of selected ticks stays within one period (`cfg_int`+1 ticks) of N·(`cfg_int` + `cfg_frac`/2^FRAC_W).
- R7: With `cfg_en`=0 or `cfg_int`=0, `out_tick` stays 0.
- R8: A setting that changes while a period is running takes effect only after that period has completed at its old length. The new setting then starts again at period 0.
- R9: `out_tick` is high for exactly the one cycle after the clock edge that sampled the tick completing a period. With `cfg_int`=1 and `cfg_frac`=0, every selected tick yields a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 9 | Tick inputs 1 to 9 (input 0 is ground) |
| alt_tick | input | 1 | Second channel offered to input 4 |
| alt_sel | input | 1 | 1 routes `alt_tick` to input 4 |
| cfg_en | input | 1 | Selector enable |
| cfg_src | input | 4 | Source select field |
| cfg_int | input | INT_W (8) | Integer part of the ratio |
| cfg_frac | input | FRAC_W (4) | Fractional part, in units of 2^-FRAC_W |
| out_tick | output | 1 | Divided single-cycle enable |

## Verification
The bench goes after the first period of a setting. A design that let stale accumulator state carry over would stretch that period, and the period-length comparison would catch the extra tick. Grounded, out-of-range and unwired selections are driven while every input toggles: a selector that decodes past the ninth input or ignores the population mask would emit pulses there. A mid-period change of the ratio checks that the running period keeps its old length; a design that switched at once would shorten or lengthen that period. A ratio of one with a tick every cycle checks that back-to-back periods do not lose a pulse.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
   localparam int NUM_SRC = 10;
   localparam int SRC_W   = 4;
   localparam int SRC_GND = 0;
   localparam int SRC_DUAL = 4;
endpackage

// File: rtl/tmf_src_pick.sv
module tmf_src_pick
   import tmf_pkg::*;
#(
   parameter int              NSRC     = NUM_SRC,
   parameter int              SEL_W    = SRC_W,
   parameter logic [NSRC-1:0] POP_MASK = '1,
   parameter bit              HAS_ALT4 = 1'b1
) (
   input  logic [NSRC-1:1]  src_tick,
   input  logic             alt_tick,
   input  logic             alt_sel,
   input  logic [SEL_W-1:0] sel,
   output logic             pick_tick,
   output logic             pick_live
);
   logic [NSRC-1:0] lane;
   logic [NSRC-1:0] wired;

   assign lane[SRC_GND]  = 1'b0;
   assign wired[SRC_GND] = 1'b0;

   for (genvar i = 1; i < NSRC; i++) begin : g_lane
      if (i == SRC_DUAL && HAS_ALT4) begin : g_dual
         assign lane[i]  = alt_sel ? alt_tick : src_tick[i];
         assign wired[i] = 1'b1;
      end else if (POP_MASK[i]) begin : g_wired
         assign lane[i]  = src_tick[i];
         assign wired[i] = 1'b1;
      end else begin : g_gnd
         assign lane[i]  = 1'b0;
         assign wired[i] = 1'b0;
      end
   end

   always_comb begin
      pick_tick = 1'b0;
      pick_live = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (sel == SEL_W'(i)) begin
            pick_tick = lane[i];
            pick_live = wired[i];
         end
      end
   end

   logic unused_inputs;
   assign unused_inputs = ^{src_tick, alt_tick, alt_sel};
endmodule

// File: rtl/tmf_frac_div.sv
module tmf_frac_div #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pick_tick,
   input  logic              pick_live,
   input  logic              cfg_en,
   input  logic [SEL_W-1:0]  cfg_src,
   input  logic [INT_W-1:0]  cfg_int,
   input  logic [FRAC_W-1:0] cfg_frac,
   output logic [SEL_W-1:0]  act_src,
   output logic [INT_W-1:0]  act_int,
   output logic              idle,
   output logic              period_end,
   output logic              out_tick
);
   localparam int CNT_W = INT_W + 1;

   logic              act_en;
   logic [FRAC_W-1:0] act_frac;
   logic [INT_W-1:0]  cnt_q;
   logic [FRAC_W-1:0] acc_q;
   logic              stretch_q;
   logic [CNT_W-1:0]  target;
   logic              last;
   logic [FRAC_W:0]   acc_sum;
   logic              cfg_diff;

   assign target     = {1'b0, act_int} + CNT_W'(stretch_q);
   assign last       = ({1'b0, cnt_q} + CNT_W'(1)) == target;
   assign idle       = !act_en || (act_int == '0) || !pick_live;
   assign period_end = !idle && pick_tick && last;
   assign acc_sum    = {1'b0, acc_q} + {1'b0, act_frac};
   assign cfg_diff   = (cfg_en != act_en) || (cfg_src != act_src) ||
                       (cfg_int != act_int) || (cfg_frac != act_frac);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en    <= 1'b0;
         act_src   <= '0;
         act_int   <= '0;
         act_frac  <= '0;
         cnt_q     <= '0;
         acc_q     <= '0;
         stretch_q <= 1'b0;
         out_tick  <= 1'b0;
      end else begin
         out_tick <= period_end;
         if (idle) begin
            act_en    <= cfg_en;
            act_src   <= cfg_src;
            act_int   <= cfg_int;
            act_frac  <= cfg_frac;
            cnt_q     <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
         end else if (pick_tick) begin
            if (last) begin
               cnt_q <= '0;
               if (cfg_diff) begin
                  act_en    <= cfg_en;
                  act_src   <= cfg_src;
                  act_int   <= cfg_int;
                  act_frac  <= cfg_frac;
                  acc_q     <= '0;
                  stretch_q <= 1'b0;
               end else begin
                  acc_q     <= acc_sum[FRAC_W-1:0];
                  stretch_q <= acc_sum[FRAC_W];
               end
            end else begin
               cnt_q <= cnt_q + INT_W'(1);
            end
         end
      end
   end

   logic unused_en;
   assign unused_en = act_en;
endmodule

// File: rtl/tick_mux_fdiv.sv
module tick_mux_fdiv
   import tmf_pkg::*;
#(
   parameter int                 INT_W    = 8,
   parameter int                 FRAC_W   = 4,
   parameter logic [NUM_SRC-1:0] POP_MASK = 10'b01_1111_1110,
   parameter bit                 HAS_ALT4 = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:1] src_tick,
   input  logic               alt_tick,
   input  logic               alt_sel,
   input  logic               cfg_en,
   input  logic [SRC_W-1:0]   cfg_src,
   input  logic [INT_W-1:0]   cfg_int,
   input  logic [FRAC_W-1:0]  cfg_frac,
   output logic               out_tick
);
   if (INT_W < 1) begin : g_bad_int
      $error("tick_mux_fdiv: INT_W must be at least 1");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("tick_mux_fdiv: FRAC_W must be at least 1");
   end
   if (POP_MASK[SRC_GND]) begin : g_bad_gnd
      $error("tick_mux_fdiv: input 0 is ground and cannot be populated");
   end
   if (HAS_ALT4 && !POP_MASK[SRC_DUAL]) begin : g_bad_dual
      $error("tick_mux_fdiv: dual-channel input 4 must be populated");
   end

   logic [SRC_W-1:0] act_src;
   logic [INT_W-1:0] act_int;
   logic             pick_tick;
   logic             pick_live;
   logic             idle;
   logic             period_end;

   tmf_src_pick #(
      .NSRC    (NUM_SRC),
      .SEL_W   (SRC_W),
      .POP_MASK(POP_MASK),
      .HAS_ALT4(HAS_ALT4)
   ) u_pick (
      .src_tick (src_tick),
      .alt_tick (alt_tick),
      .alt_sel  (alt_sel),
      .sel      (act_src),
      .pick_tick(pick_tick),
      .pick_live(pick_live)
   );

   tmf_frac_div #(
      .INT_W (INT_W),
      .FRAC_W(FRAC_W),
      .SEL_W (SRC_W)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .pick_tick (pick_tick),
      .pick_live (pick_live),
      .cfg_en    (cfg_en),
      .cfg_src   (cfg_src),
      .cfg_int   (cfg_int),
      .cfg_frac  (cfg_frac),
      .act_src   (act_src),
      .act_int   (act_int),
      .idle      (idle),
      .period_end(period_end),
      .out_tick  (out_tick)
   );
endmodule

// File: rtl/tmf_chk.sv
module tmf_chk #(
   parameter int INT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_tick,
   input logic             pick_tick,
   input logic             pick_live,
   input logic             idle,
   input logic             period_end,
   input logic [INT_W-1:0] act_int
);
   p_pulse_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> ($past(pick_tick) && !$past(idle)));

   p_end_gives_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> out_tick);

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && $past(idle)) |-> !out_tick);

   p_ground_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pick_live && $past(!pick_live)) |-> !out_tick);

   p_ratio_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_int) |-> ($past(period_end) || $past(idle)));
endmodule

bind tick_mux_fdiv tmf_chk #(.INT_W(INT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_tick  (out_tick),
   .pick_tick (pick_tick),
   .pick_live (pick_live),
   .idle      (idle),
   .period_end(period_end),
   .act_int   (act_int)
);

// File: tb/tick_mux_fdiv_bench.sv
module tick_mux_fdiv_bench;
   localparam int INT_W  = 8;
   localparam int FRAC_W = 4;
   localparam int FSCALE = 1 << FRAC_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [9:1]       src_tick = '0;
   logic             alt_tick = 1'b0;
   logic             alt_sel = 1'b0;
   logic             cfg_en = 1'b0;
   logic [3:0]       cfg_src = '0;
   logic [INT_W-1:0] cfg_int = '0;
   logic [FRAC_W-1:0] cfg_frac = '0;
   logic             out_tick;

   tick_mux_fdiv u_tick_mux_fdiv (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .alt_tick(alt_tick),
      .alt_sel(alt_sel), .cfg_en(cfg_en), .cfg_src(cfg_src),
      .cfg_int(cfg_int), .cfg_frac(cfg_frac), .out_tick(out_tick)
   );

   always #10 clk = ~clk;

   int          n_chk = 0;
   int          n_fail = 0;
   int          exp_q[$];
   int          ticks_since = 0;
   int          total_ticks = 0;
   int          n_pulses = 0;
   int          n_unexp = 0;
   bit          quiet = 1'b1;
   bit          dense = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   string       tag = "R1";

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   function automatic bit sel_model();
      if (cfg_src == 4'd4 && alt_sel) return alt_tick;
      if (cfg_src >= 4'd1 && cfg_src <= 4'd8) return src_tick[cfg_src];
      return 1'b0;
   endfunction

   function automatic int period_len(input int k, input int ip, input int fp);
      if (k == 0) return ip;
      return ip + ((k * fp) / FSCALE) - (((k - 1) * fp) / FSCALE);
   endfunction

   task automatic step();
      @(negedge clk);
      if (out_tick) begin
         n_pulses++;
         if (exp_q.size() == 0) begin
            n_unexp++;
            chk(1'b0, {tag, " unexpected pulse"}, 1, 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(ticks_since == e, {tag, " period length"}, ticks_since, e);
         end
         ticks_since = 0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (quiet) begin
         src_tick = '0;
         alt_tick = 1'b0;
      end else if (dense) begin
         src_tick = '1;
         alt_tick = 1'b1;
      end else begin
         src_tick = lfsr[9:1];
         alt_tick = lfsr[11];
      end
      if (!quiet && sel_model()) begin
         ticks_since++;
         total_ticks++;
      end
   endtask

   task automatic push_periods(input int n, input int ip, input int fp);
      for (int k = 0; k < n; k++) exp_q.push_back(period_len(k, ip, fp));
   endtask

   task automatic restart(input bit en, input int src, input int ip, input int fp,
                          input bit asel, input bit dn);
      quiet = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      cfg_en = en; cfg_src = 4'(src); cfg_int = INT_W'(ip);
      cfg_frac = FRAC_W'(fp); alt_sel = asel; dense = dn;
      exp_q.delete();
      step(); step();
      chk(out_tick == 1'b0, "R1 reset output", int'(out_tick), 0);
      rst_n = 1'b1;
      step(); step();
      ticks_since = 0; total_ticks = 0; n_pulses = 0; n_unexp = 0;
      quiet = 1'b0;
   endtask

   task automatic run_seg(input string t, input bit en, input int src, input int ip,
                          input int fp, input bit asel, input bit dn, input int n);
      int guard;
      tag = t;
      restart(en, src, ip, fp, asel, dn);
      push_periods(n, ip, fp);
      guard = 0;
      while (exp_q.size() != 0 && guard < n * (ip + 2) * 8 + 100) begin
         step();
         guard++;
      end
      chk(exp_q.size() == 0, {t, " all pulses seen"}, exp_q.size(), 0);
   endtask

   task automatic quiet_seg(input string t, input bit en, input int src, input int ip,
                            input bit asel);
      tag = t;
      restart(en, src, ip, 3, asel, 1'b0);
      for (int i = 0; i < 60; i++) step();
      dense = 1'b1;
      for (int i = 0; i < 40; i++) step();
      chk(n_pulses == 0, {t, " no output pulse"}, n_pulses, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
   end

   initial begin : main
      int guard;
      // R1: output held low through reset and the first load
      tag = "R1";
      step();
      chk(out_tick == 1'b0, "R1 output during reset", int'(out_tick), 0);

      // R2 and R5: oscillator input and a populated instance input, random gaps
      run_seg("R2 R5 src1", 1'b1, 1, 3, 5, 1'b0, 1'b0, 20);
      run_seg("R2 R5 src7", 1'b1, 7, 2, 15, 1'b0, 1'b0, 20);
      run_seg("R2 src3", 1'b1, 3, 5, 0, 1'b0, 1'b0, 8);

      // R4: dual-channel input 4 in both positions
      run_seg("R4 chanA", 1'b1, 4, 2, 0, 1'b0, 1'b0, 12);
      run_seg("R4 chanB", 1'b1, 4, 2, 6, 1'b1, 1'b0, 12);

      // R3: ground, out-of-range select, unwired input
      quiet_seg("R3 ground", 1'b1, 0, 2, 1'b0);
      quiet_seg("R3 unwired9", 1'b1, 9, 2, 1'b0);
      quiet_seg("R3 sel12", 1'b1, 12, 2, 1'b1);

      // R7: disabled, zero integer part
      quiet_seg("R7 disabled", 1'b0, 1, 2, 1'b0);
      quiet_seg("R7 int zero", 1'b1, 1, 0, 1'b0);

      // R9: ratio of one with a tick every cycle, then one plus a large fraction
      run_seg("R9 ratio1", 1'b1, 2, 1, 0, 1'b0, 1'b1, 16);
      run_seg("R9 R5 ratio1p", 1'b1, 2, 1, 15, 1'b0, 1'b1, 16);

      // R8: ratio change mid-period
      tag = "R8 old";
      restart(1'b1, 2, 4, 0, 1'b0, 1'b0);
      push_periods(3, 4, 0);
      guard = 0;
      while (exp_q.size() != 1 && guard < 400) begin step(); guard++; end
      cfg_int = INT_W'(3);
      cfg_frac = FRAC_W'(8);
      push_periods(8, 3, 8);
      tag = "R8 switch";
      guard = 0;
      while (exp_q.size() != 0 && guard < 800) begin step(); guard++; end
      chk(exp_q.size() == 0, "R8 all pulses seen", exp_q.size(), 0);

      // R6: long-run average ratio
      run_seg("R6 R5 long", 1'b1, 1, 3, 5, 1'b0, 1'b0, 200);
      chk((total_ticks * FSCALE - n_pulses * (3 * FSCALE + 5)) <= 4 * FSCALE &&
          (n_pulses * (3 * FSCALE + 5) - total_ticks * FSCALE) <= 4 * FSCALE,
          "R6 average ratio", total_ticks, n_pulses * (3 * FSCALE + 5) / FSCALE);
      chk(n_pulses == 200, "R6 pulse count", n_pulses, 200);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule